// File: doc/BRIEF.md
# Upgrade Control Serial Register Port

This block gives user logic a serial path into the registers that steer image selection for field upgrades. A 41-bit shift register sits between the serial pins and three kinds of storage. The upper two bits of the shift register choose which word a capture loads. The lower 39 bits move data in and out. A 39-bit input register holds the image-select controls. The block builds three status words from field inputs: one current-state word and two previous-state words. The machine that fills those fields lies outside this block.

Two mode inputs choose one operation per clock, and every operation changes something. With `mode_shift` high the block is in state SHIFT. With `mode_shift` low, `mode_capture` high gives state CAPTURE and `mode_capture` low gives state UPDATE. The operation is decoded again on every clock edge, so any state can follow any other. There is no idle setting.

To write, user logic shifts in a 39-bit word, least significant bit first, then applies one UPDATE clock. To read, it shifts in two selector bits, applies one CAPTURE clock, then shifts 39 bits out of `ser_out`, least significant bit first.

Top module: `upg_serial_port`

## Requirements
- R1: After reset the shift register and the input register are all zero. `ser_out`, `img_sel` and `img_override` are 0.
- R2: In SHIFT (`mode_shift`=1) the low 39 bits become {ser_in, sr[38:1]} and the selector pair sr[40:39] becomes {ser_in, sr[40]}. `mode_capture` has no effect in this state.
- R3: In UPDATE (both mode inputs 0) the input register loads sr[38:0] and the shift register keeps its value.
- R4: A CAPTURE with selector 00 loads sr[38:0] with the current-state word: state code in bits 33:30, watchdog-enable in bit 29, 29-bit time-out in bits 28:0, all other bits zero.
- R5: A CAPTURE with selector 01 or 10 loads sr[38:0] with previous-state word 1 or 2. Each word is zero-extended and has its cause flags in bits 31:27, its state code in bits 25:22, and zeros in bit 26, bits 21:0 and bits 38:32.
- R6: A CAPTURE with selector 11 loads sr[38:0] from the input register. No capture changes the input register or the selector pair.
- R7: `ser_out` presents sr[0], so each SHIFT clock brings the next more significant bit to the output.
- R8: `img_sel` follows input register bit 13 and `img_override` follows input register bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data into the shift register |
| mode_shift | input | 1 | 1 selects SHIFT |
| mode_capture | input | 1 | With mode_shift low: 1 selects CAPTURE, 0 selects UPDATE |
| st_code | input | 4 | Current state code |
| wd_en | input | 1 | Current watchdog-enable flag |
| wd_timeout | input | 29 | Current watchdog time-out value |
| p1_cause | input | 5 | Cause flags, previous-state word 1 |
| p1_code | input | 4 | State code, previous-state word 1 |
| p2_cause | input | 5 | Cause flags, previous-state word 2 |
| p2_code | input | 4 | State code, previous-state word 2 |
| ser_out | output | 1 | Serial data out (shift register bit 0) |
| img_override | output | 1 | Input register bit 12: override of the image-select pin |
| img_sel | output | 1 | Input register bit 13: selected image |

## Verification
The bench builds the block with its default parameters: a 39-bit input register, a 29-bit time-out, 4-bit state codes and 5-bit cause flags. It sweeps all four capture selectors against four status patterns. One pattern sets every field to all ones, so each field boundary and each reserved zero can be seen in the serial readback. All four combinations of the two image-control bits pass through UPDATE and are read back, and `mode_capture` toggles throughout the shifting to show that SHIFT ignores it.

// File: rtl/upg_port_pkg.sv
package upg_port_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [1:0] {
        OP_UPDATE  = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        SRC_CUR   = 2'd0,
        SRC_PREV1 = 2'd1,
        SRC_PREV2 = 2'd2,
        SRC_INREG = 2'd3
    } src_e;
endpackage

// File: rtl/upg_op_decode.sv
module upg_op_decode
    import upg_port_pkg::*;
(
    input  logic mode_shift,
    input  logic mode_capture,
    output op_e  op
);
    always_comb begin
        unique case ({mode_shift, mode_capture})
            2'b00:   op = OP_UPDATE;
            2'b01:   op = OP_CAPTURE;
            default: op = OP_SHIFT;
        endcase
    end
endmodule

// File: rtl/upg_capture_mux.sv
module upg_capture_mux
    import upg_port_pkg::*;
#(
    parameter int IN_W      = 39,
    parameter int TO_W      = 29,
    parameter int CODE_W    = 4,
    parameter int CAUSE_W   = 5,
    parameter int PCODE_LSB = 22
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [CODE_W-1:0]  st_code,
    input  logic               wd_en,
    input  logic [TO_W-1:0]    wd_timeout,
    input  logic [CAUSE_W-1:0] p1_cause,
    input  logic [CODE_W-1:0]  p1_code,
    input  logic [CAUSE_W-1:0] p2_cause,
    input  logic [CODE_W-1:0]  p2_code,
    input  logic [IN_W-1:0]    in_reg,
    output logic [IN_W-1:0]    cap_word
);
    localparam int CUR_W      = TO_W + 1 + CODE_W;
    localparam int PCAUSE_LSB = PCODE_LSB + CODE_W + 1;

    logic [IN_W-1:0]    cur_w;
    logic [IN_W-1:0]    prev_w  [2];
    logic [CAUSE_W-1:0] cause_a [2];
    logic [CODE_W-1:0]  code_a  [2];

    assign cause_a[0] = p1_cause;
    assign cause_a[1] = p2_cause;
    assign code_a[0]  = p1_code;
    assign code_a[1]  = p2_code;

    always_comb begin
        cur_w            = '0;
        cur_w[CUR_W-1:0] = {st_code, wd_en, wd_timeout};
    end

    for (genvar g = 0; g < 2; g++) begin : g_prev
        always_comb begin
            prev_w[g]                          = '0;
            prev_w[g][PCODE_LSB +: CODE_W]     = code_a[g];
            prev_w[g][PCAUSE_LSB +: CAUSE_W]   = cause_a[g];
        end
    end

    always_comb begin
        unique case (src_e'(sel))
            SRC_CUR:   cap_word = cur_w;
            SRC_PREV1: cap_word = prev_w[0];
            SRC_PREV2: cap_word = prev_w[1];
            default:   cap_word = in_reg;
        endcase
    end
endmodule

// File: rtl/upg_shift_reg.sv
module upg_shift_reg
    import upg_port_pkg::*;
#(
    parameter int IN_W = 39
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  op_e                   op,
    input  logic                  ser_in,
    input  logic [IN_W-1:0]       cap_word,
    output logic [IN_W+SEL_W-1:0] sr_q
);
    localparam int SR_W = IN_W + SEL_W;

    logic [SR_W-1:0] sr_d;

    always_comb begin
        sr_d = sr_q;
        unique case (op)
            OP_SHIFT: begin
                sr_d[SR_W-1:IN_W] = {ser_in, sr_q[SR_W-1:IN_W+1]};
                sr_d[IN_W-1:0]    = {ser_in, sr_q[IN_W-1:1]};
            end
            OP_CAPTURE: sr_d[IN_W-1:0] = cap_word;
            default:    sr_d = sr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end
endmodule

// File: rtl/upg_input_reg.sv
module upg_input_reg
    import upg_port_pkg::*;
#(
    parameter int IN_W    = 39,
    parameter int SEL_BIT = 13,
    parameter int OVR_BIT = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  op_e             op,
    input  logic [IN_W-1:0] sr_low,
    output logic [IN_W-1:0] ir_q,
    output logic            img_sel,
    output logic            img_override
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ir_q <= '0;
        else if (op == OP_UPDATE)  ir_q <= sr_low;
    end

    assign img_sel      = ir_q[SEL_BIT];
    assign img_override = ir_q[OVR_BIT];
endmodule

// File: rtl/upg_serial_port.sv
module upg_serial_port
    import upg_port_pkg::*;
#(
    parameter int IN_W      = 39,
    parameter int TO_W      = 29,
    parameter int CODE_W    = 4,
    parameter int CAUSE_W   = 5,
    parameter int PCODE_LSB = 22,
    parameter int SEL_BIT   = 13,
    parameter int OVR_BIT   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_in,
    input  logic               mode_shift,
    input  logic               mode_capture,
    input  logic [CODE_W-1:0]  st_code,
    input  logic               wd_en,
    input  logic [TO_W-1:0]    wd_timeout,
    input  logic [CAUSE_W-1:0] p1_cause,
    input  logic [CODE_W-1:0]  p1_code,
    input  logic [CAUSE_W-1:0] p2_cause,
    input  logic [CODE_W-1:0]  p2_code,
    output logic               ser_out,
    output logic               img_override,
    output logic               img_sel
);
    localparam int SR_W = IN_W + SEL_W;

    op_e             op;
    logic [SR_W-1:0] sr_q;
    logic [IN_W-1:0] ir_q;
    logic [IN_W-1:0] cap_word;

    upg_op_decode u_dec (
        .mode_shift   (mode_shift),
        .mode_capture (mode_capture),
        .op           (op)
    );

    upg_capture_mux #(
        .IN_W(IN_W), .TO_W(TO_W), .CODE_W(CODE_W),
        .CAUSE_W(CAUSE_W), .PCODE_LSB(PCODE_LSB)
    ) u_mux (
        .sel        (sr_q[SR_W-1:IN_W]),
        .st_code    (st_code),
        .wd_en      (wd_en),
        .wd_timeout (wd_timeout),
        .p1_cause   (p1_cause),
        .p1_code    (p1_code),
        .p2_cause   (p2_cause),
        .p2_code    (p2_code),
        .in_reg     (ir_q),
        .cap_word   (cap_word)
    );

    upg_shift_reg #(.IN_W(IN_W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .ser_in   (ser_in),
        .cap_word (cap_word),
        .sr_q     (sr_q)
    );

    upg_input_reg #(.IN_W(IN_W), .SEL_BIT(SEL_BIT), .OVR_BIT(OVR_BIT)) u_ir (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .sr_low       (sr_q[IN_W-1:0]),
        .ir_q         (ir_q),
        .img_sel      (img_sel),
        .img_override (img_override)
    );

    assign ser_out = sr_q[0];
endmodule

// File: rtl/upg_serial_port_chk.sv
module upg_serial_port_chk #(
    parameter int IN_W      = 39,
    parameter int TO_W      = 29,
    parameter int CODE_W    = 4,
    parameter int CAUSE_W   = 5,
    parameter int PCODE_LSB = 22,
    parameter int SEL_BIT   = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ser_in,
    input logic               mode_shift,
    input logic               mode_capture,
    input logic [CODE_W-1:0]  st_code,
    input logic               wd_en,
    input logic [TO_W-1:0]    wd_timeout,
    input logic [CAUSE_W-1:0] p1_cause,
    input logic [CODE_W-1:0]  p1_code,
    input logic               ser_out,
    input logic               img_sel,
    input logic [IN_W+1:0]    sr,
    input logic [IN_W-1:0]    ir
);
    localparam int SR_W = IN_W + 2;

    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_shift |=> (sr[IN_W-1] == $past(ser_in)) &&
                       (sr[IN_W-2:0] == $past(sr[IN_W-1:1])));

    p_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_shift && !mode_capture) |=> (ir == $past(sr[IN_W-1:0])) &&
                                           (sr == $past(sr)));

    p_cap_cur_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_shift && mode_capture && sr[SR_W-1:IN_W] == 2'b00) |=>
        sr[IN_W-1:0] == IN_W'({$past(st_code), $past(wd_en), $past(wd_timeout)}));

    p_cap_prev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_shift && mode_capture && sr[SR_W-1:IN_W] == 2'b01) |=>
        sr[IN_W-1:0] == (IN_W'({$past(p1_cause), 1'b0, $past(p1_code)}) << PCODE_LSB));

    p_cap_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_shift && mode_capture) |=> $stable(ir) &&
                                         (sr[SR_W-1:IN_W] == $past(sr[SR_W-1:IN_W])));

    p_ser_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_shift |=> ser_out == $past(sr[1]));

    p_img_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_shift && !mode_capture) |=> img_sel == $past(sr[SEL_BIT]));
endmodule

bind upg_serial_port upg_serial_port_chk #(
    .IN_W(IN_W), .TO_W(TO_W), .CODE_W(CODE_W), .CAUSE_W(CAUSE_W),
    .PCODE_LSB(PCODE_LSB), .SEL_BIT(SEL_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_in       (ser_in),
    .mode_shift   (mode_shift),
    .mode_capture (mode_capture),
    .st_code      (st_code),
    .wd_en        (wd_en),
    .wd_timeout   (wd_timeout),
    .p1_cause     (p1_cause),
    .p1_code      (p1_code),
    .ser_out      (ser_out),
    .img_sel      (img_sel),
    .sr           (sr_q),
    .ir           (ir_q)
);

// File: tb/tb_upg_serial_port.sv
module tb_upg_serial_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        mode_shift = 1'b1;
    logic        mode_capture = 1'b0;
    logic [3:0]  st_code = '0;
    logic        wd_en = 1'b0;
    logic [28:0] wd_timeout = '0;
    logic [4:0]  p1_cause = '0;
    logic [3:0]  p1_code = '0;
    logic [4:0]  p2_cause = '0;
    logic [3:0]  p2_code = '0;
    logic        ser_out, img_override, img_sel;

    int checks = 0;
    int fails  = 0;
    logic [38:0] ir_exp = '0;

    upg_serial_port dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
        .mode_shift(mode_shift), .mode_capture(mode_capture),
        .st_code(st_code), .wd_en(wd_en), .wd_timeout(wd_timeout),
        .p1_cause(p1_cause), .p1_code(p1_code),
        .p2_cause(p2_cause), .p2_code(p2_code),
        .ser_out(ser_out), .img_override(img_override), .img_sel(img_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [38:0] got, input logic [38:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // one clock: drive at falling edge, return just after the rising edge
    task automatic step(input logic s, input logic c, input logic d);
        @(negedge clk);
        mode_shift = s; mode_capture = c; ser_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic load_bits(input logic [38:0] w, input int n);
        for (int i = 0; i < n; i++) step(1'b1, i[0], w[i]);
    endtask

    task automatic read_word(output logic [38:0] w);
        for (int i = 0; i < 39; i++) begin
            w[i] = ser_out;
            step(1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic capture_sel(input logic [1:0] s, output logic [38:0] w);
        step(1'b1, 1'b0, s[0]);
        step(1'b1, 1'b1, s[1]);
        step(1'b0, 1'b1, 1'b0);
        read_word(w);
    endtask

    function automatic logic [38:0] exp_cur();
        return 39'({st_code, wd_en, wd_timeout});
    endfunction

    function automatic logic [38:0] exp_prev(input logic [4:0] ca, input logic [3:0] co);
        return 39'({ca, 1'b0, co, 22'b0});
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [38:0] got;
        logic [38:0] w;
        st_code = 4'h5; wd_en = 1'b1; wd_timeout = 29'h0ABC_DEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 ser_out", 39'(ser_out), 39'd0);
        chk("R1 img_sel", 39'(img_sel), 39'd0);
        chk("R1 img_override", 39'(img_override), 39'd0);
        // selector reset to 00: capture gives the current-state word
        step(1'b0, 1'b1, 1'b0);
        read_word(got);
        chk("R1/R4 capture after reset", got, exp_cur());

        for (int p = 0; p < 4; p++) begin
            st_code    = (p == 3) ? 4'hF : 4'(p * 5 + 2);
            wd_en      = (p == 3) ? 1'b1 : p[0];
            wd_timeout = (p == 3) ? 29'h1FFF_FFFF : 29'(32'h0123_4567 * (p + 1));
            p1_cause   = (p == 3) ? 5'h1F : 5'(p * 7 + 1);
            p1_code    = (p == 3) ? 4'hF : 4'(p + 9);
            p2_cause   = (p == 3) ? 5'h1F : 5'(p * 3 + 16);
            p2_code    = (p == 3) ? 4'hF : 4'(6 - p);
            for (int s = 0; s < 4; s++) begin
                capture_sel(2'(s), got);
                case (s)
                    0: chk("R4 current word", got, exp_cur());
                    1: chk("R5 previous word 1", got, exp_prev(p1_cause, p1_code));
                    2: chk("R5 previous word 2", got, exp_prev(p2_cause, p2_code));
                    default: chk("R6 input register", got, ir_exp);
                endcase
            end
        end

        for (int k = 0; k < 4; k++) begin
            w = '0;
            w[13] = k[1];
            w[12] = k[0];
            w[11:0] = 12'(12'h555 * (k + 1));
            load_bits(w, 39);               // mode_capture toggles: R2 ignore
            step(1'b0, 1'b0, 1'b0);         // UPDATE
            ir_exp = w;
            chk("R8 img_sel", 39'(img_sel), 39'(k[1]));
            chk("R8 img_override", 39'(img_override), 39'(k[0]));
            read_word(got);
            chk("R2/R3/R7 shift register held through update", got, w);
            capture_sel(2'b11, got);
            chk("R6 input register readback", got, w);
            chk("R6 capture leaves img_sel", 39'(img_sel), 39'(k[1]));
            chk("R6 capture leaves img_override", 39'(img_override), 39'(k[0]));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule